// File: doc/BRIEF.md
# Speaker Load Diagnostic Sequencer

This block runs the open/short load test on a four-channel class-D amplifier. A control register interface hands it a channel mask and a start pulse. It asks the output stage to park those channels in Hi-Z. It waits until every selected channel reports Hi-Z and has finished its pop-free ramp. It then walks through timed test phases, and all timing comes from a 1 ms tick input.

In each phase the block samples one external comparator flag per channel: short to ground, short to supply, open load or shorted load. It ORs the sampled value into a sticky result nibble for that channel. If all four channels sit in Hi-Z when testing begins, the full level runs all four phases on every channel at once. Otherwise the reduced level runs only the two short phases, on the selected channels. Software reads two 8-bit result registers, and a per-register read strobe clears them.

Top module: `load_diag_seq`

## Requirements
- R1: A `start` pulse with a nonzero `ch_sel` while idle latches the mask and drives `force_hiz` equal to it from the next cycle until the run ends. A `start` pulse with an empty mask, or one that arrives during a run, changes nothing.
- R2: No phase begins (`in_diag` stays 0) until every selected channel has `hiz_stat` high and `ramp_busy` low.
- R3: When all four `hiz_stat` bits are high as testing begins, the full level runs. It tests all four channels (`in_diag` = 4'hF) through the phases short-to-ground, short-to-supply, open load and shorted load, in that order.
- R4: Otherwise the reduced level runs. Only the short-to-ground and short-to-supply phases run, `in_diag` equals the selected mask, and no open-load or shorted-load bit gets set.
- R5: Phase lengths in ticks are 20 for each short phase, 100 for open load and 230 for shorted load. With `ext_time` latched high, each short phase lasts 80 ticks.
- R6: With `gap_en` latched high, a 20-tick pause separates each pair of successive phases. No pause follows the final phase.
- R7: Each flag is sampled only on the last tick of its phase. Channel c owns bits [4c+3:4c] of {`diag_hi`,`diag_lo`}. Inside a nibble, bit 0 is short to ground, bit 1 short to supply, bit 2 shorted load and bit 3 open load.
- R8: Result bits hold until cleared. `rd_clr[0]` clears `diag_lo` and `rd_clr[1]` clears `diag_hi`, each on the following cycle.
- R9: As testing begins, the nibbles of the channels about to be tested are zeroed. The nibbles of the other channels are kept.
- R10: One cycle after the last tick of the final phase, `diag_done` is high for exactly one cycle. In that same cycle `in_diag` and `force_hiz` return to 0 and the results already show the final phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| start | input | 1 | Run request pulse |
| ch_sel | input | 4 | Channels requested for test |
| ext_time | input | 1 | Stretch both short phases by four |
| gap_en | input | 1 | Insert a pause between phases |
| hiz_stat | input | 4 | Per-channel output is in Hi-Z |
| ramp_busy | input | 4 | Per-channel pop-free transition still in progress |
| cmp_gnd | input | 4 | Short-to-ground comparator flags |
| cmp_sup | input | 4 | Short-to-supply comparator flags |
| cmp_open | input | 4 | Open-load comparator flags |
| cmp_shl | input | 4 | Shorted-load comparator flags |
| rd_clr | input | 2 | Clear-on-read strobes for the two result registers |
| force_hiz | output | 4 | Request to hold channels in Hi-Z |
| in_diag | output | 4 | Channels currently under test |
| diag_lo | output | 8 | Results for channels 0 and 1 |
| diag_hi | output | 8 | Results for channels 2 and 3 |
| diag_done | output | 1 | Run-complete pulse |

## Verification
The hardest situation to reach from the ports is a comparator flag that changes inside a phase. A run with flags that stay constant cannot tell sampling on the last tick apart from sampling on any other tick. The bench therefore counts ticks while `in_diag` is high, and in two directed runs it drives the channel-0 ground flag from that count. In one run the flag drops exactly at the final tick of the phase, and in the other it is high only on that tick. A second hard case is a long pop-free ramp. Random delays hold `ramp_busy` high while the bench checks every cycle that no phase has started, and a start pulse injected during a run confirms that the request is ignored.

// File: rtl/load_diag_pkg.sv
package load_diag_pkg;

    localparam int unsigned NCH = 4;

    localparam int unsigned B_GND  = 0;
    localparam int unsigned B_SUP  = 1;
    localparam int unsigned B_SHL  = 2;
    localparam int unsigned B_OPEN = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_GND  = 2'd0,
        PH_SUP  = 2'd1,
        PH_OPEN = 2'd2,
        PH_SHL  = 2'd3
    } phase_e;

    typedef struct packed {
        seq_state_e     st;
        phase_e         ph;
        logic           full;
        logic           ext;
        logic           gap;
        logic [NCH-1:0] sel;
        logic [NCH-1:0] tested;
        logic           done;
    } seq_regs_t;

endpackage

// File: rtl/diag_phase_plan.sv
module diag_phase_plan
    import load_diag_pkg::*;
#(
    parameter int unsigned SG_TICKS = 20,
    parameter int unsigned OL_TICKS = 100,
    parameter int unsigned SL_TICKS = 230,
    parameter int unsigned STRETCH  = 4,
    parameter int unsigned CW       = 8
) (
    input  phase_e          ph,
    input  logic            ext,
    input  logic            full,
    output logic [CW-1:0]   len,
    output logic            final_ph,
    output phase_e          nxt
);

    localparam logic [CW-1:0] SG_L  = CW'(SG_TICKS);
    localparam logic [CW-1:0] SGX_L = CW'(SG_TICKS * STRETCH);
    localparam logic [CW-1:0] OL_L  = CW'(OL_TICKS);
    localparam logic [CW-1:0] SL_L  = CW'(SL_TICKS);

    always_comb begin
        len      = SG_L;
        final_ph = 1'b0;
        nxt      = PH_GND;
        case (ph)
            PH_GND: begin
                len = ext ? SGX_L : SG_L;
                nxt = PH_SUP;
            end
            PH_SUP: begin
                len      = ext ? SGX_L : SG_L;
                nxt      = PH_OPEN;
                final_ph = !full;
            end
            PH_OPEN: begin
                len = OL_L;
                nxt = PH_SHL;
            end
            default: begin
                len      = SL_L;
                final_ph = 1'b1;
                nxt      = PH_GND;
            end
        endcase
    end

endmodule

// File: rtl/diag_timer.sv
module diag_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = run && tick && (cnt_q == limit - 1'b1);
        cnt_d = cnt_q;
        if (!run || last) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/diag_result_bank.sv
module diag_result_bank
    import load_diag_pkg::*;
#(
    parameter  int unsigned NC   = 4,
    localparam int unsigned NB   = NC * 4,
    localparam int unsigned NREG = NB / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NC-1:0]   wipe,
    input  logic            cap,
    input  phase_e          cap_ph,
    input  logic [NC-1:0]   tested,
    input  logic [NC-1:0]   f_gnd,
    input  logic [NC-1:0]   f_sup,
    input  logic [NC-1:0]   f_open,
    input  logic [NC-1:0]   f_shl,
    input  logic [NREG-1:0] rd_clr,
    output logic [NB-1:0]   res
);

    logic [NB-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        for (int r = 0; r < NREG; r++) begin
            if (rd_clr[r]) begin
                res_d[r*8 +: 8] = '0;
            end
        end
        for (int c = 0; c < NC; c++) begin
            if (wipe[c]) begin
                res_d[c*4 +: 4] = '0;
            end
            if (cap && tested[c]) begin
                case (cap_ph)
                    PH_GND:  res_d[c*4 + B_GND]  = res_d[c*4 + B_GND]  | f_gnd[c];
                    PH_SUP:  res_d[c*4 + B_SUP]  = res_d[c*4 + B_SUP]  | f_sup[c];
                    PH_OPEN: res_d[c*4 + B_OPEN] = res_d[c*4 + B_OPEN] | f_open[c];
                    default: res_d[c*4 + B_SHL]  = res_d[c*4 + B_SHL]  | f_shl[c];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res = res_q;

endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
    import load_diag_pkg::*;
#(
    parameter int unsigned SG_TICKS  = 20,
    parameter int unsigned OL_TICKS  = 100,
    parameter int unsigned SL_TICKS  = 230,
    parameter int unsigned GAP_TICKS = 20,
    parameter int unsigned STRETCH   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       start,
    input  logic [3:0] ch_sel,
    input  logic       ext_time,
    input  logic       gap_en,
    input  logic [3:0] hiz_stat,
    input  logic [3:0] ramp_busy,
    input  logic [3:0] cmp_gnd,
    input  logic [3:0] cmp_sup,
    input  logic [3:0] cmp_open,
    input  logic [3:0] cmp_shl,
    input  logic [1:0] rd_clr,
    output logic [3:0] force_hiz,
    output logic [3:0] in_diag,
    output logic [7:0] diag_lo,
    output logic [7:0] diag_hi,
    output logic       diag_done
);

    localparam int unsigned SGX  = SG_TICKS * STRETCH;
    localparam int unsigned M1   = (SGX > OL_TICKS) ? SGX : OL_TICKS;
    localparam int unsigned M2   = (M1 > SL_TICKS) ? M1 : SL_TICKS;
    localparam int unsigned MAXL = (M2 > GAP_TICKS) ? M2 : GAP_TICKS;
    localparam int unsigned CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] GAP_L = CW'(GAP_TICKS);

    seq_regs_t r_d, r_q;

    logic [CW-1:0] ph_len, t_limit;
    logic          ph_final, t_run, t_last, cap;
    phase_e        ph_nxt;
    logic [NCH-1:0] wipe, ready_v;
    logic [NCH*4-1:0] res;

    diag_phase_plan #(
        .SG_TICKS (SG_TICKS),
        .OL_TICKS (OL_TICKS),
        .SL_TICKS (SL_TICKS),
        .STRETCH  (STRETCH),
        .CW       (CW)
    ) u_plan (
        .ph       (r_q.ph),
        .ext      (r_q.ext),
        .full     (r_q.full),
        .len      (ph_len),
        .final_ph (ph_final),
        .nxt      (ph_nxt)
    );

    assign t_run   = (r_q.st == ST_RUN) || (r_q.st == ST_GAP);
    assign t_limit = (r_q.st == ST_GAP) ? GAP_L : ph_len;

    diag_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .tick  (tick_ms),
        .limit (t_limit),
        .last  (t_last)
    );

    assign ready_v = ~r_q.sel | (hiz_stat & ~ramp_busy);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cap      = 1'b0;
        wipe     = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start && (|ch_sel)) begin
                    r_d.st  = ST_WAIT;
                    r_d.sel = ch_sel;
                    r_d.ext = ext_time;
                    r_d.gap = gap_en;
                end
            end
            ST_WAIT: begin
                if (&ready_v) begin
                    r_d.full   = &hiz_stat;
                    r_d.tested = (&hiz_stat) ? '1 : r_q.sel;
                    r_d.ph     = PH_GND;
                    r_d.st     = ST_RUN;
                    wipe       = r_d.tested;
                end
            end
            ST_RUN: begin
                if (t_last) begin
                    cap = 1'b1;
                    if (ph_final) begin
                        r_d.st     = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.tested = '0;
                        r_d.sel    = '0;
                    end else begin
                        r_d.ph = ph_nxt;
                        r_d.st = r_q.gap ? ST_GAP : ST_RUN;
                    end
                end
            end
            default: begin
                if (t_last) begin
                    r_d.st = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_GND, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    diag_result_bank #(.NC(NCH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (wipe),
        .cap    (cap),
        .cap_ph (r_q.ph),
        .tested (r_q.tested),
        .f_gnd  (cmp_gnd),
        .f_sup  (cmp_sup),
        .f_open (cmp_open),
        .f_shl  (cmp_shl),
        .rd_clr (rd_clr),
        .res    (res)
    );

    assign force_hiz = r_q.sel;
    assign in_diag   = r_q.tested;
    assign diag_lo   = res[7:0];
    assign diag_hi   = res[15:8];
    assign diag_done = r_q.done;

endmodule

// File: rtl/load_diag_seq_chk.sv
module load_diag_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] hiz_stat,
    input logic [3:0] ramp_busy,
    input logic [1:0] rd_clr,
    input logic [3:0] force_hiz,
    input logic [3:0] in_diag,
    input logic [7:0] diag_lo,
    input logic [7:0] diag_hi,
    input logic       diag_done
);

    logic [7:0] ol_sl;
    assign ol_sl = {diag_hi[7:6], diag_hi[3:2], diag_lo[7:6], diag_lo[3:2]};

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|in_diag) && ($past(in_diag) == 4'h0))
        |-> $past(&(~force_hiz | (hiz_stat & ~ramp_busy))));

    p_scope_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_diag) |-> ((in_diag == 4'hF) || (in_diag == force_hiz)));

    p_reduced_no_ol_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|in_diag) && (in_diag != 4'hF)) |=> ((ol_sl & ~$past(ol_sl)) == 8'h00));

    p_rd_clear_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr[0] && (in_diag == 4'h0)) |=> (diag_lo == 8'h00));

    p_rd_clear_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr[1] && (in_diag == 4'h0)) |=> (diag_hi == 8'h00));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((force_hiz == 4'h0) && (rd_clr == 2'b00)) |=> ($stable(diag_lo) && $stable(diag_hi)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        diag_done |=> !diag_done);

    p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        diag_done |-> ((in_diag == 4'h0) && (force_hiz == 4'h0) && ($past(in_diag) != 4'h0)));

endmodule

bind load_diag_seq load_diag_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hiz_stat  (hiz_stat),
    .ramp_busy (ramp_busy),
    .rd_clr    (rd_clr),
    .force_hiz (force_hiz),
    .in_diag   (in_diag),
    .diag_lo   (diag_lo),
    .diag_hi   (diag_hi),
    .diag_done (diag_done)
);

// File: tb/load_diag_seq_tb.sv
module load_diag_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       start = 1'b0;
    logic [3:0] ch_sel = '0;
    logic       ext_time = 1'b0;
    logic       gap_en = 1'b0;
    logic [3:0] hiz_stat = '0;
    logic [3:0] ramp_busy = '0;
    logic [3:0] cmp_gnd;
    logic [3:0] cmp_sup = '0;
    logic [3:0] cmp_open = '0;
    logic [3:0] cmp_shl = '0;
    logic [1:0] rd_clr = '0;
    logic [3:0] force_hiz, in_diag;
    logic [7:0] diag_lo, diag_hi;
    logic       diag_done;

    always #2 clk = ~clk;

    load_diag_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start(start),
        .ch_sel(ch_sel), .ext_time(ext_time), .gap_en(gap_en),
        .hiz_stat(hiz_stat), .ramp_busy(ramp_busy),
        .cmp_gnd(cmp_gnd), .cmp_sup(cmp_sup), .cmp_open(cmp_open),
        .cmp_shl(cmp_shl), .rd_clr(rd_clr), .force_hiz(force_hiz),
        .in_diag(in_diag), .diag_lo(diag_lo), .diag_hi(diag_hi),
        .diag_done(diag_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] model = '0;

    int tick_div = 0;
    int run_ticks = 0;
    int gnd_mode = 0;
    logic [3:0] gnd_base = '0;
    int sg_now = 20;

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick_ms  = (tick_div == 0);
        if (force_hiz != 4'h0 && in_diag == 4'h0) run_ticks = 0;
        if (tick_ms && in_diag != 4'h0) run_ticks = run_ticks + 1;
        case (gnd_mode)
            1: cmp_gnd = {gnd_base[3:1], (run_ticks < sg_now)};
            2: cmp_gnd = {gnd_base[3:1], (tick_ms && in_diag != 4'h0 && run_ticks == sg_now)};
            default: cmp_gnd = gnd_base;
        endcase
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_ticks(input bit full, input bit ext, input bit gap);
        int sg = ext ? 80 : 20;
        int n = 2 * sg + (full ? 330 : 0);
        if (gap) n += 20 * (full ? 3 : 1);
        return n;
    endfunction

    function automatic logic [15:0] model_run(input logic [15:0] old, input logic [3:0] tst, input bit full,
                                             input logic [3:0] g, input logic [3:0] s,
                                             input logic [3:0] o, input logic [3:0] l, input int mode);
        logic [15:0] m = old;
        for (int c = 0; c < 4; c++) begin
            if (tst[c]) begin
                logic gb = g[c];
                if (c == 0 && mode == 1) gb = 1'b0;
                if (c == 0 && mode == 2) gb = 1'b1;
                m[c*4 +: 4] = {o[c] & full, l[c] & full, s[c], gb};
            end
        end
        return m;
    endfunction

    task automatic do_run(input logic [3:0] sel, input logic [3:0] other, input bit ext, input bit gap,
                          input logic [3:0] g, input logic [3:0] s, input logic [3:0] o, input logic [3:0] l,
                          input int mode, input int delay, input bit inject);
        bit full = ((other | sel) == 4'hF);
        logic [3:0] tst = full ? 4'hF : sel;
        logic [3:0] seen = '0;
        bit quiet = 1;
        bit got = 0;
        @(negedge clk);
        ch_sel = sel; ext_time = ext; gap_en = gap;
        gnd_base = g; cmp_sup = s; cmp_open = o; cmp_shl = l;
        gnd_mode = mode; sg_now = ext ? 80 : 20;
        hiz_stat = other & ~sel; ramp_busy = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(force_hiz == sel, "R1 force_hiz after start", force_hiz, sel);
        for (int i = 0; i < delay; i++) begin
            if (in_diag != 4'h0) quiet = 0;
            @(negedge clk);
        end
        check(quiet && in_diag == 4'h0, "R2 no phase during ramp", in_diag, 0);
        hiz_stat = other | sel; ramp_busy = '0;
        for (int i = 0; i < 6000; i++) begin
            if (diag_done) begin got = 1; break; end
            if (in_diag != 4'h0 && seen == 4'h0) begin
                seen = in_diag;
                if (inject) begin
                    ch_sel = ~sel; start = 1'b1;
                    @(negedge clk);
                    start = 1'b0; ch_sel = sel;
                    check(force_hiz == sel, "R1 start ignored while busy", force_hiz, sel);
                    continue;
                end
            end
            @(negedge clk);
        end
        check(got, "R10 done seen", got, 1);
        model = model_run(model, tst, full, g, s, o, l, mode);
        check(seen == tst, full ? "R3 full tested mask" : "R4 reduced tested mask", seen, tst);
        check(run_ticks == exp_ticks(full, ext, gap), "R5 R6 run length in ticks", run_ticks, exp_ticks(full, ext, gap));
        check({diag_hi, diag_lo} == model, "R7 R9 result registers", {diag_hi, diag_lo}, model);
        check(in_diag == 4'h0 && force_hiz == 4'h0, "R10 release at done", {force_hiz, in_diag}, 0);
        @(negedge clk);
        check(diag_done == 1'b0, "R10 done single cycle", diag_done, 0);
        gnd_mode = 0;
    endtask

    task automatic read_clear(input logic [1:0] which);
        @(negedge clk);
        rd_clr = which;
        @(negedge clk);
        rd_clr = 2'b00;
        if (which[0]) model[7:0] = '0;
        if (which[1]) model[15:8] = '0;
        check({diag_hi, diag_lo} == model, "R8 clear on read", {diag_hi, diag_lo}, model);
        repeat (5) @(negedge clk);
        check({diag_hi, diag_lo} == model, "R8 results held", {diag_hi, diag_lo}, model);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(diag_lo == 0 && diag_hi == 0, "R8 reset results", {diag_hi, diag_lo}, 0);
        check(force_hiz == 0 && in_diag == 0 && diag_done == 0, "R1 reset idle", {force_hiz, in_diag}, 0);

        ch_sel = 4'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(force_hiz == 4'h0, "R1 empty mask ignored", force_hiz, 0);

        do_run(4'hF, 4'h0, 0, 0, 4'hF, 4'hF, 4'hF, 4'hF, 0, 3, 0);
        do_run(4'h4, 4'h3, 1, 1, 4'h0, 4'h0, 4'h0, 4'h0, 0, 10, 1);
        read_clear(2'b01);
        read_clear(2'b10);
        do_run(4'h1, 4'h0, 0, 0, 4'h1, 4'h0, 4'hF, 4'hF, 1, 2, 0);
        do_run(4'h1, 4'h0, 0, 1, 4'h0, 4'h1, 4'h0, 4'h0, 2, 0, 0);
        do_run(4'h3, 4'hC, 1, 1, 4'h5, 4'hA, 4'h3, 4'h6, 0, 20, 0);

        for (int k = 0; k < 8; k++) begin
            logic [3:0] sel_r = 4'($urandom_range(1, 15));
            logic [3:0] oth_r = 4'($urandom);
            do_run(sel_r, oth_r, 1'($urandom), 1'($urandom),
                   4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                   0, int'($urandom_range(0, 40)), 0);
            if ($urandom_range(0, 1) == 1) read_clear(2'($urandom_range(1, 3)));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule